// File: doc/BRIEF.md
# Packed BCD Arithmetic Unit

This unit does decimal arithmetic on one byte that holds two packed BCD digits (tens digit in bits 7..4, units digit in bits 3..0). It supports three operations: add, subtract and negate. Each one takes an incoming extend bit as a decimal carry-in or borrow-in. Alongside the result byte it returns extend, carry, zero, negative and overflow flags. The correction arithmetic runs on any byte pattern, including digits above 9, and gives a fixed result for each.

Wider decimal strings are processed one byte at a time, lowest byte first. The caller passes the extend and zero flags from one byte into the next. The zero flag can only be cleared and is never set. If it enters set ahead of the first byte, it leaves set only when every byte of the string came out zero.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream, through a single output register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged.

Top module: `bcd_arith_unit`

## Requirements
- R1: Add (op code 0) computes dst + src + extend. If the units sum exceeds 9, 6 is added. If the running value then exceeds 0x9F, 0x60 is added. The result is the low 8 bits.
- R2: After an add, carry and extend are equal, and both are set exactly when the corrected value has a bit set above bit 7.
- R3: After an add, overflow = bit 7 of the corrected value AND NOT bit 7 of the plain binary sum dst + src + extend.
- R4: Subtract (op code 1) computes dst - src - extend. 6 is removed when the units difference is negative, and 0x60 is removed when the binary difference is negative. The result is the low 8 bits.
- R5: After a subtract or negate, carry and extend are equal, and both are set when bit 8 or bit 9 of (binary difference minus the units correction) is set, in 10-bit two's complement.
- R6: After a subtract or negate, overflow = bit 7 of the binary difference AND NOT bit 7 of the corrected result.
- R7: Negate (op code 2) behaves as subtract with a left operand of zero and the source as the right operand; dst is ignored. Op code 3 behaves exactly as op code 2.
- R8: The zero output equals the zero input when the result byte is zero, and is clear otherwise.
- R9: The negative output equals bit 7 of the result byte.
- R10: A request is accepted on a clock edge with in_valid and in_ready high. out_valid is high in the next cycle. in_ready = NOT out_valid OR out_ready. Reset empties the output register.
- R11: While out_valid is high and out_ready is low, out_valid and all result outputs keep their values.
- R12: When both operand bytes hold valid digits (0..9), the result holds valid digits and the operation is decimally exact: add gives 100*carry + result = dst + src + extend, and subtract/negate give result - 100*carry = left - right - extend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 2 | 0 add, 1 subtract, 2 or 3 negate |
| in_src | input | 8 | Source byte (right operand) |
| in_dst | input | 8 | Destination byte (left operand for add/subtract) |
| in_x | input | 1 | Incoming extend (carry/borrow in) |
| in_z | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_value | output | 8 | Result byte |
| out_x | output | 1 | Extend out |
| out_c | output | 1 | Carry out |
| out_z | output | 1 | Zero out |
| out_n | output | 1 | Negative out |
| out_v | output | 1 | Overflow out |

## Verification
Some properties are asserted on every cycle: decimal exactness and valid result digits for well-formed operands, a next-cycle result after every accepted request, results held under a stall, and a zero flag that never goes from clear to set. The exact correction behaviour for malformed digits can only be shown by the bench's scenarios, and so can the overflow and carry bit positions, the negate operand swap with its alias code, and throughput under back-pressure. The bench sweeps every byte pair for add and subtract and every source for negate, then runs a mixed stream with gaps and stalls.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  localparam int BYTE_W     = 8;
  localparam int NIB_W      = 4;
  localparam int WIDE_W     = BYTE_W + 2;
  localparam int OP_W       = 2;
  localparam int DIGIT_MAX  = 9;
  localparam int DIGIT_ADJ  = 6;
  localparam int HIGH_LIMIT = 'h9F;
  localparam int HIGH_ADJ   = 'h60;
  localparam int RADIX_SQ   = 100;

  typedef enum logic [OP_W-1:0] {
    BCD_OP_ADD    = 2'd0,
    BCD_OP_SUB    = 2'd1,
    BCD_OP_NEG    = 2'd2,
    BCD_OP_NEGALT = 2'd3
  } bcd_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] value;
    logic              ext;
    logic              carry;
    logic              zero;
    logic              neg;
    logic              ovf;
  } bcd_result_t;

  function automatic logic digits_ok(input logic [BYTE_W-1:0] b);
    return (b[NIB_W-1:0] <= NIB_W'(DIGIT_MAX)) &&
           (b[BYTE_W-1:NIB_W] <= NIB_W'(DIGIT_MAX));
  endfunction

  function automatic int dec_of(input logic [BYTE_W-1:0] b);
    return int'(b[BYTE_W-1:NIB_W]) * 10 + int'(b[NIB_W-1:0]);
  endfunction

endpackage

// File: rtl/bcd_add_core.sv
module bcd_add_core
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] a_dst,
  input  logic [BYTE_W-1:0] a_src,
  input  logic              a_x,
  output logic [BYTE_W-1:0] a_sum,
  output logic              a_carry,
  output logic              a_ovf
);
  localparam int LoW = NIB_W + 2;

  logic [LoW-1:0]    lo_raw, lo_fix;
  logic [WIDE_W-1:0] bin_sum, run, fixed;

  always_comb begin
    lo_raw  = LoW'(a_dst[NIB_W-1:0]) + LoW'(a_src[NIB_W-1:0]) + LoW'(a_x);
    lo_fix  = (lo_raw > LoW'(DIGIT_MAX)) ? lo_raw + LoW'(DIGIT_ADJ) : lo_raw;
    bin_sum = WIDE_W'(a_dst) + WIDE_W'(a_src) + WIDE_W'(a_x);
    run     = WIDE_W'({a_dst[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
            + WIDE_W'({a_src[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
            + WIDE_W'(lo_fix);
    fixed   = (run > WIDE_W'(HIGH_LIMIT)) ? run + WIDE_W'(HIGH_ADJ) : run;
    a_sum   = fixed[BYTE_W-1:0];
    a_carry = |fixed[WIDE_W-1:BYTE_W];
    a_ovf   = fixed[BYTE_W-1] & ~bin_sum[BYTE_W-1];

    if (digits_ok(a_dst) && digits_ok(a_src)) begin
      // R12
      add_decimal_chk: assert (digits_ok(fixed[BYTE_W-1:0]) &&
        (dec_of(fixed[BYTE_W-1:0]) + RADIX_SQ * int'(|fixed[WIDE_W-1:BYTE_W])
         == dec_of(a_dst) + dec_of(a_src) + int'(a_x)))
        else $error("decimal add mismatch");
    end
  end

endmodule

// File: rtl/bcd_sub_core.sv
module bcd_sub_core
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] s_lhs,
  input  logic [BYTE_W-1:0] s_rhs,
  input  logic              s_x,
  output logic [BYTE_W-1:0] s_diff,
  output logic              s_carry,
  output logic              s_ovf
);
  logic [WIDE_W-1:0] bin_diff, lo_raw, lo_corr, hi_corr, tens, full, borrow_src;

  always_comb begin
    bin_diff   = WIDE_W'(s_lhs) - WIDE_W'(s_rhs) - WIDE_W'(s_x);
    lo_raw     = WIDE_W'(s_lhs[NIB_W-1:0]) - WIDE_W'(s_rhs[NIB_W-1:0]) - WIDE_W'(s_x);
    lo_corr    = lo_raw[WIDE_W-1]   ? WIDE_W'(DIGIT_ADJ) : '0;
    hi_corr    = bin_diff[WIDE_W-1] ? WIDE_W'(HIGH_ADJ)  : '0;
    tens       = WIDE_W'({s_lhs[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
               - WIDE_W'({s_rhs[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
               - hi_corr;
    full       = lo_raw + tens - lo_corr;
    borrow_src = bin_diff - lo_corr;
    s_diff     = full[BYTE_W-1:0];
    s_carry    = |borrow_src[WIDE_W-1:BYTE_W];
    s_ovf      = bin_diff[BYTE_W-1] & ~full[BYTE_W-1];

    if (digits_ok(s_lhs) && digits_ok(s_rhs)) begin
      // R12
      sub_decimal_chk: assert (digits_ok(full[BYTE_W-1:0]) &&
        (dec_of(full[BYTE_W-1:0]) - RADIX_SQ * int'(|borrow_src[WIDE_W-1:BYTE_W])
         == dec_of(s_lhs) - dec_of(s_rhs) - int'(s_x)))
        else $error("decimal subtract mismatch");
    end
  end

endmodule

// File: rtl/bcd_flag_merge.sv
module bcd_flag_merge
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] m_value,
  input  logic              m_carry,
  input  logic              m_ovf,
  input  logic              m_z_in,
  output bcd_result_t       m_res
);
  logic seen_nonzero;

  always_comb begin
    seen_nonzero  = ~m_z_in | (|m_value);
    m_res.value   = m_value;
    m_res.carry   = m_carry;
    m_res.ext     = m_carry;
    m_res.zero    = ~seen_nonzero;
    m_res.neg     = m_value[BYTE_W-1];
    m_res.ovf     = m_ovf;
  end

endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [BYTE_W-1:0] in_src,
  input  logic [BYTE_W-1:0] in_dst,
  input  logic              in_x,
  input  logic              in_z,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_value,
  output logic              out_x,
  output logic              out_c,
  output logic              out_z,
  output logic              out_n,
  output logic              out_v
);
  bcd_op_e           op;
  logic              is_add;
  logic [BYTE_W-1:0] sub_lhs;
  logic [BYTE_W-1:0] add_sum, sub_diff, pick_value;
  logic              add_c, add_v, sub_c, sub_v, pick_c, pick_v;
  bcd_result_t       next_res, held;
  logic              hold_valid;
  logic              accept;

  always_comb begin
    op      = bcd_op_e'(in_op);
    is_add  = (op == BCD_OP_ADD);
    sub_lhs = (op == BCD_OP_NEG || op == BCD_OP_NEGALT) ? '0 : in_dst;
  end

  bcd_add_core u_add (
    .a_dst   (in_dst),
    .a_src   (in_src),
    .a_x     (in_x),
    .a_sum   (add_sum),
    .a_carry (add_c),
    .a_ovf   (add_v)
  );

  bcd_sub_core u_sub (
    .s_lhs   (sub_lhs),
    .s_rhs   (in_src),
    .s_x     (in_x),
    .s_diff  (sub_diff),
    .s_carry (sub_c),
    .s_ovf   (sub_v)
  );

  always_comb begin
    pick_value = is_add ? add_sum : sub_diff;
    pick_c     = is_add ? add_c   : sub_c;
    pick_v     = is_add ? add_v   : sub_v;
  end

  bcd_flag_merge u_flags (
    .m_value (pick_value),
    .m_carry (pick_c),
    .m_ovf   (pick_v),
    .m_z_in  (in_z),
    .m_res   (next_res)
  );

  assign in_ready = ~hold_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      held       <= '0;
    end else begin
      if (accept) begin
        hold_valid <= 1'b1;
        held       <= next_res;
      end else if (out_ready) begin
        hold_valid <= 1'b0;
      end
    end
  end

  assign out_valid = hold_valid;
  assign out_value = held.value;
  assign out_x     = held.ext;
  assign out_c     = held.carry;
  assign out_z     = held.zero;
  assign out_n     = held.neg;
  assign out_v     = held.ovf;

  // R10
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_x)
      && $stable(out_c) && $stable(out_z) && $stable(out_n) && $stable(out_v));

  // R8
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_z |=> !out_z);

endmodule

// File: tb/test_bcd_arith_unit.sv
module test_bcd_arith_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_ADD   = 65536;
  localparam int N_SUB   = 65536;
  localparam int N_NEG   = 512;
  localparam int N_MIX   = 1024;
  localparam int BASE_SUB = N_ADD;
  localparam int BASE_NEG = N_ADD + N_SUB;
  localparam int BASE_MIX = BASE_NEG + N_NEG;
  localparam int N_TOTAL  = BASE_MIX + N_MIX;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_op = '0;
  logic [7:0] in_src = '0, in_dst = '0;
  logic in_x = 1'b0, in_z = 1'b0;
  logic out_valid, out_ready = 1'b0;
  logic [7:0] out_value;
  logic out_x, out_c, out_z, out_n, out_v;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    int op; int d; int s; int x; int z;
    int value; int c; int zo; int n; int v;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_arith_unit i_bcd_arith_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_src(in_src), .in_dst(in_dst), .in_x(in_x), .in_z(in_z),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_x(out_x), .out_c(out_c),
    .out_z(out_z), .out_n(out_n), .out_v(out_v)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int dec2(input int b);
    return (b / 16) * 10 + (b % 16);
  endfunction

  function automatic bit good(input int b);
    return (b % 16) <= 9 && (b / 16) <= 9;
  endfunction

  // Behavioural reference from the requirements.
  function automatic exp_t model(input int op, input int d, input int s, input int x, input int z);
    exp_t e;
    int lo, r, u, lc, hc, l;
    e.op = op; e.d = d; e.s = s; e.x = x; e.z = z;
    if (op == 0) begin
      lo = (d % 16) + (s % 16) + x;
      if (lo > 9) lo += 6;
      r = lo + (d / 16) * 16 + (s / 16) * 16;
      if (r > 'h9F) r += 'h60;
      e.value = r % 256;
      e.c = (r > 255) ? 1 : 0;
      e.v = ((r & 128) != 0 && ((d + s + x) & 128) == 0) ? 1 : 0;
    end else begin
      l  = (op == 1) ? d : 0;
      u  = l - s - x;
      lo = (l % 16) - (s % 16) - x;
      lc = (lo < 0) ? 6 : 0;
      hc = (u < 0) ? 'h60 : 0;
      r  = lo + (l / 16) * 16 - (s / 16) * 16 - hc - lc;
      e.value = r & 255;
      e.c = (((u - lc) & 'h300) != 0) ? 1 : 0;
      e.v = ((u & 128) != 0 && (r & 128) == 0) ? 1 : 0;
    end
    e.zo = (e.value == 0) ? z : 0;
    e.n  = (e.value >= 128) ? 1 : 0;
    return e;
  endfunction

  task automatic gen(input int k, output int op, output int d, output int s,
                     output int x, output int z);
    int m;
    if (k < BASE_SUB) begin
      op = 0; d = (k >> 8) & 255; s = k & 255;
      x = ((k ^ (k >> 8)) & 1); z = (k >> 1) & 1;
    end else if (k < BASE_NEG) begin
      m = k - BASE_SUB;
      op = 1; d = (m >> 8) & 255; s = m & 255;
      x = ((m ^ (m >> 9)) & 1); z = (m >> 2) & 1;
    end else if (k < BASE_MIX) begin
      m = k - BASE_NEG;
      op = 2; s = m & 255; x = (m >> 8) & 1;
      d = (m * 37 + 91) & 255; z = (m >> 3) & 1;
    end else begin
      m = k - BASE_MIX;
      op = m % 4; d = (m * 73 + 5) & 255; s = (m * 151 + 7) & 255;
      x = (m >> 3) & 1; z = (m >> 4) & 1;
      if ((m % 16) == 0) begin d = 0; s = 0; z = 1; x = 0; end
    end
  endtask

  task automatic compare(input exp_t e);
    string rv, rc, rx;
    if (e.op == 0) begin rv = "R1"; rc = "R2"; rx = "R3"; end
    else if (e.op == 1) begin rv = "R4"; rc = "R5"; rx = "R6"; end
    else begin rv = "R7"; rc = "R5"; rx = "R6"; end
    chk(int'(out_value) == e.value, rv, int'(out_value), e.value);
    chk(int'(out_c) == e.c, rc, int'(out_c), e.c);
    chk(int'(out_x) == e.c, rc, int'(out_x), e.c);
    chk(int'(out_v) == e.v, rx, int'(out_v), e.v);
    chk(int'(out_z) == e.zo, "R8", int'(out_z), e.zo);
    chk(int'(out_n) == e.n, "R9", int'(out_n), e.n);
    if (good(e.s) && (e.op != 1 || good(e.d)) && (e.op != 0 || good(e.d))) begin
      // R12: decimal exactness on well-formed digits
      if (e.op == 0)
        chk(good(int'(out_value)) && dec2(int'(out_value)) + 100 * int'(out_c)
            == dec2(e.d) + dec2(e.s) + e.x, "R12", int'(out_value), e.value);
      else
        chk(good(int'(out_value)) && dec2(int'(out_value)) - 100 * int'(out_c)
            == ((e.op == 1) ? dec2(e.d) : 0) - dec2(e.s) - e.x, "R12",
            int'(out_value), e.value);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int k = 0;
    int cyc = 0;
    int op, d, s, x, z;
    bit prev_stall = 0;
    logic [12:0] held_vals = '0;
    exp_t e;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R10: reset state
    chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R10", int'(in_ready), 1);

    while (k < N_TOTAL || q.size() != 0) begin
      @(negedge clk);
      cyc++;
      if (k >= BASE_MIX) out_ready = (cyc % 3) != 0;
      else               out_ready = 1'b1;
      if (k < N_TOTAL && !(k >= BASE_MIX && (cyc % 5) == 0)) begin
        gen(k, op, d, s, x, z);
        in_valid = 1'b1;
        in_op = 2'(op); in_dst = 8'(d); in_src = 8'(s);
        in_x = x[0]; in_z = z[0];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      // R11: held under stall
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R11", int'(out_valid), 1);
        chk({out_value, out_x, out_c, out_z, out_n, out_v} == held_vals, "R11",
            int'({out_value, out_x, out_c, out_z, out_n, out_v}), int'(held_vals));
      end
      // R10: ready rule and occupancy
      chk(in_ready == (!out_valid || out_ready), "R10", int'(in_ready),
          int'(!out_valid || out_ready));
      chk(out_valid == (q.size() != 0), "R10", int'(out_valid), int'(q.size() != 0));
      if (out_valid && out_ready && q.size() != 0) begin
        e = q.pop_front();
        compare(e);
      end
      if (in_valid && in_ready) begin
        q.push_back(model(op, d, s, x, z));
        k++;
      end
      prev_stall = out_valid && !out_ready;
      held_vals  = {out_value, out_x, out_c, out_z, out_n, out_v};
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule